// File: doc/BRIEF.md
# DMA Channel Descriptor-Count Controller

This block is the control core of one DMA channel. Software points the channel at a descriptor chain by writing its base address, then tells it how much work exists by writing an absolute 16-bit descriptor total. The block compares that total with an internal count of consumed descriptors. While the two differ, it issues the address of the next descriptor to a descriptor engine, one descriptor at a time. Each finished descriptor, whether completed or skipped, advances the consumed count by one. Software appends work by raising the total, and the comparison wraps modulo 2^16.

A command byte carries two actions, suspend and reset. A reset forces the channel to Halted and drops any descriptor in flight. A command write that sets both actions is illegal. It raises a sticky fatal flag, which holds the channel Halted until a reset command or a system reset. Count and command writes take effect only when the channel-count configuration input is 1. The address of the most recently completed descriptor is kept for status reads.

Top module: `dmach_ctrl`

## Requirements
- R1: A chain-address write stores the base address and, on the next cycle, shows count_o = 0 and consumed_o = 0 with no descriptor outstanding. It takes priority over a count write in the same cycle.
- R2: req_valid_o is high exactly when the state is Active and no descriptor is outstanding. req_addr_o = base + consumed_o * 64, modulo 2^32. A cycle with req_valid_o and req_ready_i both high makes that descriptor outstanding.
- R3: A done_i pulse while a descriptor is outstanding adds one to consumed_o, modulo 2^16, and ends the outstanding descriptor. done_i is ignored while nothing is outstanding.
- R4: state_o codes are 0 Halted, 1 Active, 2 Idle and 3 Suspended. Outside Halted and with suspend clear, the state is Active when count_o differs from consumed_o and Idle when they are equal. Because the count is absolute and compared with wraparound, a total below the consumed value still restarts work.
- R5: last_done_o takes the address of the finished descriptor when done_i is high and skip_i is low. A skipped descriptor (done_i and skip_i both high) leaves it unchanged.
- R6: A command write with bit 5 set (and bit 2 clear) moves the channel to Halted. It drops the outstanding descriptor and clears suspend and fatal, and it leaves count_o, consumed_o and last_done_o unchanged.
- R7: A command write with bit 2 set moves a non-Halted channel to Suspended, which issues no requests. A later command write with bit 2 clear returns it to Active or Idle according to R4. cmd_o shows the suspend flag at bit 2, and every other bit of cmd_o reads 0.
- R8: When chan_cnt_i is not 1, count and command writes are ignored, including their fatal check.
- R9: A command write with bits 5 and 2 both set sets fatal_o and forces Halted. While fatal_o is high the state stays Halted even if a count write creates work, and only a reset command or a system reset clears fatal_o.
- R10: After system reset the state is Halted and all outputs are 0. Halted is left only by an accepted count write that creates work: the channel goes to Suspended if suspend is set, otherwise to Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_cnt_i | input | 8 | Channel-count configuration; count and command writes accepted only when it is 1 |
| wr_chain_i | input | 1 | Chain-address write strobe |
| chain_addr_i | input | 32 | Chain base address |
| wr_count_i | input | 1 | Descriptor-count write strobe |
| count_i | input | 16 | Absolute descriptor total |
| wr_cmd_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command byte: bit 5 reset, bit 2 suspend |
| req_valid_o | output | 1 | Next descriptor address offered |
| req_addr_o | output | 32 | Address of the next descriptor |
| req_ready_i | input | 1 | Engine accepts the offered descriptor |
| done_i | input | 1 | Outstanding descriptor finished |
| skip_i | input | 1 | Qualifies done_i as a skip |
| state_o | output | 2 | Channel state code |
| count_o | output | 16 | Descriptor total register |
| consumed_o | output | 16 | Consumed-descriptor counter |
| last_done_o | output | 32 | Address of the last completed descriptor |
| fatal_o | output | 1 | Sticky illegal-command flag |
| cmd_o | output | 8 | Command readback |

## Verification
The main flow is driven in four ways. A short chain mixes completions and skips, which separates the consumed count from the last-completed address. Totals are appended while the channel is busy and while it is idle, which shows the count is absolute rather than additive. A free-running engine consumes a full 65535-descriptor chain and then a total that wraps past 0xFFFF, which exposes any comparison that is not modulo 2^16. Finally, command writes are made as single bits, with both bits set, with only reserved bits set, and while the channel-count input is locked. This tells apart reset, suspend, fatal handling and ignored writes.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_ACT  = 2'd1,
    ST_IDLE = 2'd2,
    ST_SUSP = 2'd3
  } chan_state_e;

  localparam int CMD_RST_BIT  = 5;
  localparam int CMD_SUSP_BIT = 2;

  // number of action bits raised by one command write
  function automatic logic [1:0] f_action_hits(input logic rst_bit, input logic susp_bit);
    return {1'b0, rst_bit} + {1'b0, susp_bit};
  endfunction
endpackage

// File: rtl/dmach_cmd_dec.sv
module dmach_cmd_dec
  import dmach_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             wr_cmd_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             unlocked_i,
  output logic             rst_cmd_o,
  output logic             bad_cmd_o,
  output logic             susp_wr_o,
  output logic             susp_val_o
);
  logic       take;
  logic [1:0] hits;

  always_comb begin
    take       = wr_cmd_i && unlocked_i;
    hits       = f_action_hits(cmd_i[CMD_RST_BIT], cmd_i[CMD_SUSP_BIT]);
    bad_cmd_o  = take && (hits > 2'd1);
    rst_cmd_o  = take && !bad_cmd_o && cmd_i[CMD_RST_BIT];
    susp_wr_o  = take && !bad_cmd_o && !cmd_i[CMD_RST_BIT];
    susp_val_o = cmd_i[CMD_SUSP_BIT];
  end

  always_comb begin
    a_one_action_r9: assert (!(rst_cmd_o && bad_cmd_o) && !(susp_wr_o && bad_cmd_o));
  end
endmodule

// File: rtl/dmach_progress.sv
module dmach_progress #(
  parameter int AW         = 32,
  parameter int CNT_W      = 16,
  parameter int DESC_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_chain_i,
  input  logic [AW-1:0]    chain_addr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             drop_i,
  input  logic             issue_i,
  input  logic             done_i,
  input  logic             skip_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] consumed_o,
  output logic             busy_o,
  output logic [AW-1:0]    last_o,
  output logic [AW-1:0]    req_addr_o,
  output logic             work_now_o,
  output logic             work_nxt_o
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

  function automatic logic [AW-1:0] f_slot_addr(input logic [AW-1:0] base,
                                                input logic [CNT_W-1:0] idx);
    return base + AW'(idx) * STRIDE;
  endfunction

  function automatic logic f_has_work(input logic [CNT_W-1:0] total,
                                      input logic [CNT_W-1:0] used);
    return total != used;
  endfunction

  logic [AW-1:0]    base_q, issued_q;
  logic [CNT_W-1:0] cnt_nxt, cons_nxt;
  logic             finish, abandon;

  always_comb begin
    abandon    = wr_chain_i || drop_i;
    finish     = busy_o && done_i && !abandon;
    cons_nxt   = wr_chain_i ? '0 : (finish ? consumed_o + 1'b1 : consumed_o);
    cnt_nxt    = wr_chain_i ? '0 : (cnt_wr_i ? count_i : count_o);
    work_now_o = f_has_work(count_o, consumed_o);
    work_nxt_o = f_has_work(cnt_nxt, cons_nxt);
    req_addr_o = f_slot_addr(base_q, consumed_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      issued_q   <= '0;
      count_o    <= '0;
      consumed_o <= '0;
      busy_o     <= 1'b0;
      last_o     <= '0;
    end else begin
      count_o    <= cnt_nxt;
      consumed_o <= cons_nxt;
      if (wr_chain_i) base_q <= chain_addr_i;
      if (issue_i) issued_q <= req_addr_o;
      if (finish && !skip_i) last_o <= issued_q;
      if (abandon || finish) busy_o <= 1'b0;
      else if (issue_i) busy_o <= 1'b1;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chain_i |=> (count_o == '0) && (consumed_o == '0) && !busy_o);
  p_single_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !issue_i);
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i && !wr_chain_i && !drop_i) |=> consumed_o == $past(consumed_o) + 1'b1);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_chain_i && !(busy_o && done_i)) |=> $stable(consumed_o));
  p_skip_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i && skip_i) |=> $stable(last_o));
endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
  import dmach_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_cmd_i,
  input  logic        bad_cmd_i,
  input  logic        susp_wr_i,
  input  logic        susp_val_i,
  input  logic        cnt_wr_i,
  input  logic        work_now_i,
  input  logic        work_nxt_i,
  output chan_state_e state_o,
  output logic        susp_o,
  output logic        fatal_o
);
  chan_state_e st_nxt;
  logic        susp_nxt, fatal_nxt;

  always_comb begin
    fatal_nxt = bad_cmd_i ? 1'b1 : (rst_cmd_i ? 1'b0 : fatal_o);
    susp_nxt  = rst_cmd_i ? 1'b0 : (susp_wr_i ? susp_val_i : susp_o);
    if (bad_cmd_i || rst_cmd_i || fatal_o) begin
      st_nxt = ST_HALT;
    end else if (state_o == ST_HALT) begin
      if (cnt_wr_i && work_nxt_i) st_nxt = susp_nxt ? ST_SUSP : ST_ACT;
      else st_nxt = ST_HALT;
    end else if (susp_nxt) begin
      st_nxt = ST_SUSP;
    end else begin
      st_nxt = work_nxt_i ? ST_ACT : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= ST_HALT;
      susp_o  <= 1'b0;
      fatal_o <= 1'b0;
    end else begin
      state_o <= st_nxt;
      susp_o  <= susp_nxt;
      fatal_o <= fatal_nxt;
    end
  end

  p_idle_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE) |-> !work_now_i);
  p_active_work_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACT) |-> work_now_i);
  p_reset_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_i |=> (state_o == ST_HALT) && !fatal_o && !susp_o);
  p_susp_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SUSP) |-> susp_o);
  p_fatal_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> (state_o == ST_HALT));
  p_fatal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_o && !rst_cmd_i) |=> fatal_o);
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CNT_W      = 16,
  parameter int CMD_W      = 8,
  parameter int CFG_W      = 8,
  parameter int DESC_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] chan_cnt_i,
  input  logic             wr_chain_i,
  input  logic [AW-1:0]    chain_addr_i,
  input  logic             wr_count_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_cmd_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             req_valid_o,
  output logic [AW-1:0]    req_addr_o,
  input  logic             req_ready_i,
  input  logic             done_i,
  input  logic             skip_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] consumed_o,
  output logic [AW-1:0]    last_done_o,
  output logic             fatal_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic        unlocked, cnt_wr, issue, busy;
  logic        rst_cmd, bad_cmd, susp_wr, susp_val, susp;
  logic        work_now, work_nxt;
  chan_state_e state;

  assign unlocked    = (chan_cnt_i == CFG_W'(1));
  assign cnt_wr      = wr_count_i && unlocked;
  assign req_valid_o = (state == ST_ACT) && !busy;
  assign issue       = req_valid_o && req_ready_i;
  assign state_o     = state;

  always_comb begin
    cmd_o = '0;
    cmd_o[CMD_SUSP_BIT] = susp;
  end

  dmach_cmd_dec #(.CMD_W(CMD_W)) u_dec (
    .wr_cmd_i   (wr_cmd_i),
    .cmd_i      (cmd_i),
    .unlocked_i (unlocked),
    .rst_cmd_o  (rst_cmd),
    .bad_cmd_o  (bad_cmd),
    .susp_wr_o  (susp_wr),
    .susp_val_o (susp_val)
  );

  dmach_progress #(.AW(AW), .CNT_W(CNT_W), .DESC_BYTES(DESC_BYTES)) u_prog (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_chain_i   (wr_chain_i),
    .chain_addr_i (chain_addr_i),
    .cnt_wr_i     (cnt_wr),
    .count_i      (count_i),
    .drop_i       (rst_cmd || bad_cmd),
    .issue_i      (issue),
    .done_i       (done_i),
    .skip_i       (skip_i),
    .count_o      (count_o),
    .consumed_o   (consumed_o),
    .busy_o       (busy),
    .last_o       (last_done_o),
    .req_addr_o   (req_addr_o),
    .work_now_o   (work_now),
    .work_nxt_o   (work_nxt)
  );

  dmach_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_cmd_i  (rst_cmd),
    .bad_cmd_i  (bad_cmd),
    .susp_wr_i  (susp_wr),
    .susp_val_i (susp_val),
    .cnt_wr_i   (cnt_wr),
    .work_now_i (work_now),
    .work_nxt_i (work_nxt),
    .state_o    (state),
    .susp_o     (susp),
    .fatal_o    (fatal_o)
  );

  p_locked_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count_i && !unlocked && !wr_chain_i) |=> $stable(count_o));
  p_locked_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_i && !unlocked) |=> $stable(cmd_o) && $stable(fatal_o));
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmd_o) <= 1);
endmodule

// File: tb/test_dmach_ctrl.sv
`timescale 1ns/1ps
module test_dmach_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chan_cnt = 8'd1;
  logic        wr_chain = 1'b0, wr_count = 1'b0, wr_cmd = 1'b0;
  logic [31:0] chain_addr = '0;
  logic [15:0] count_in = '0;
  logic [7:0]  cmd_in = '0;
  logic        req_ready = 1'b0, done = 1'b0, skip = 1'b0;
  logic        req_valid, fatal;
  logic [31:0] req_addr, last_done;
  logic [1:0]  state;
  logic [15:0] count_o, consumed;
  logic [7:0]  cmd_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dmach_ctrl i_dmach_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_cnt_i(chan_cnt),
    .wr_chain_i(wr_chain), .chain_addr_i(chain_addr),
    .wr_count_i(wr_count), .count_i(count_in),
    .wr_cmd_i(wr_cmd), .cmd_i(cmd_in),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_ready_i(req_ready),
    .done_i(done), .skip_i(skip),
    .state_o(state), .count_o(count_o), .consumed_o(consumed),
    .last_done_o(last_done), .fatal_o(fatal), .cmd_o(cmd_o)
  );

  // behavioural reference: 0 halted, 1 active, 2 idle, 3 suspended
  int          m_state = 0;
  logic [15:0] m_cnt = '0, m_cons = '0;
  logic [31:0] m_base = '0, m_last = '0, m_slot = '0;
  bit          m_busy = 0, m_fatal = 0, m_susp = 0;

  always @(posedge clk) begin
    bit unl, take_cmd, bad, rcmd, fin, acc, cw;
    if (!rst_n) begin
      m_state = 0; m_cnt = '0; m_cons = '0; m_base = '0; m_last = '0;
      m_slot = '0; m_busy = 0; m_fatal = 0; m_susp = 0;
    end else begin
      unl      = (chan_cnt == 8'd1);
      take_cmd = unl && wr_cmd;
      bad      = take_cmd && cmd_in[5] && cmd_in[2];
      rcmd     = take_cmd && cmd_in[5] && !cmd_in[2];
      cw       = unl && wr_count;
      acc      = (m_state == 1) && !m_busy && req_ready;
      fin      = m_busy && done && !wr_chain && !bad && !rcmd;
      if (fin) begin
        if (!skip) m_last = m_slot;
        m_cons = m_cons + 16'd1;
        m_busy = 0;
      end
      if (acc) begin
        m_slot = m_base + {16'd0, m_cons} * 32'd64;
        m_busy = 1;
      end
      if (wr_chain) begin
        m_base = chain_addr; m_cnt = '0; m_cons = '0; m_busy = 0;
      end else if (cw) begin
        m_cnt = count_in;
      end
      if (bad) begin
        m_fatal = 1; m_busy = 0;
      end else if (rcmd) begin
        m_fatal = 0; m_susp = 0; m_busy = 0;
      end else if (take_cmd) begin
        m_susp = cmd_in[2];
      end
      if (bad || rcmd || m_fatal) m_state = 0;
      else if (m_state == 0) begin
        if (cw && m_cnt != m_cons) m_state = m_susp ? 3 : 1;
      end else if (m_susp) m_state = 3;
      else m_state = (m_cnt != m_cons) ? 1 : 2;
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    chk("R4", "state", 64'(state), 64'(m_state));
    chk("R2", "req_valid", 64'(req_valid), 64'(m_state == 1 && !m_busy));
    chk("R2", "req_addr", 64'(req_addr), 64'(m_base + {16'd0, m_cons} * 32'd64));
    chk("R1", "count", 64'(count_o), 64'(m_cnt));
    chk("R3", "consumed", 64'(consumed), 64'(m_cons));
    chk("R5", "last_done", 64'(last_done), 64'(m_last));
    chk("R9", "fatal", 64'(fatal), 64'(m_fatal));
    chk("R7", "cmd_o", 64'(cmd_o), 64'(m_susp ? 8'h04 : 8'h00));
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_chain(input logic [31:0] a);
    wr_chain = 1'b1; chain_addr = a; tick(1); wr_chain = 1'b0;
  endtask
  task automatic do_count(input logic [15:0] n);
    wr_count = 1'b1; count_in = n; tick(1); wr_count = 1'b0;
  endtask
  task automatic do_cmd(input logic [7:0] c);
    wr_cmd = 1'b1; cmd_in = c; tick(1); wr_cmd = 1'b0;
  endtask
  task automatic do_done(input logic s);
    done = 1'b1; skip = s; tick(1); done = 1'b0; skip = 1'b0;
  endtask

  bit finished = 0;

  initial begin
    tick(3);
    chk("R10", "reset state", 64'(state), 64'd0);
    chk("R10", "reset outputs", 64'(count_o | consumed | last_done | req_addr), 64'd0);
    rst_n = 1'b1;
    tick(1);

    // R1 chain write then short chain with completions and a skip
    do_chain(32'h0000_1000);
    chk("R1", "cleared", 64'(count_o), 64'd0);
    do_count(16'd3);
    chk("R10", "halted to active", 64'(state), 64'd1);
    req_ready = 1'b1;
    tick(2);
    do_done(1'b0);
    chk("R5", "first completion", 64'(last_done), 64'h1000);
    tick(1);
    do_done(1'b1);
    chk("R5", "skip keeps last", 64'(last_done), 64'h1000);
    tick(1);
    do_done(1'b0);
    chk("R4", "idle when equal", 64'(state), 64'd2);
    do_done(1'b0);
    chk("R3", "done ignored when idle", 64'(consumed), 64'd3);

    // R4 absolute append and R7 suspend/resume
    do_count(16'd5);
    tick(1);
    do_cmd(8'h04);
    chk("R7", "suspended", 64'(state), 64'd3);
    do_done(1'b0);
    tick(2);
    chk("R7", "no request while suspended", 64'(req_valid), 64'd0);
    do_cmd(8'h00);
    chk("R7", "resume active", 64'(state), 64'd1);
    tick(2);

    // R8 locked writes ignored
    chan_cnt = 8'd2;
    do_count(16'd9);
    do_cmd(8'h24);
    chk("R8", "locked count", 64'(count_o), 64'd5);
    chk("R8", "locked cmd", 64'(fatal), 64'd0);
    chan_cnt = 8'd1;

    // R6 reset command
    do_cmd(8'h20);
    chk("R6", "reset cmd halts", 64'(state), 64'd0);
    chk("R6", "count kept", 64'(count_o), 64'd5);
    tick(2);
    do_count(16'd7);
    tick(2);

    // R9 illegal command, sticky fatal
    do_cmd(8'h24);
    chk("R9", "fatal set", 64'(fatal), 64'd1);
    do_count(16'd8);
    chk("R9", "held halted", 64'(state), 64'd0);
    do_cmd(8'h20);
    chk("R9", "fatal cleared", 64'(fatal), 64'd0);
    do_count(16'd9);
    tick(2);

    // R7 reserved bits, suspend with reserved noise
    do_cmd(8'hDB);
    do_cmd(8'hCF);
    chk("R7", "reserved read zero", 64'(cmd_o), 64'h04);
    do_cmd(8'h00);
    tick(1);

    // R1 chain write while busy
    do_chain(32'h0000_8000);
    chk("R1", "chain clears", 64'(consumed), 64'd0);
    do_done(1'b0);

    // R4 wraparound with a free-running engine
    do_count(16'hFFFF);
    done = 1'b1;
    for (int i = 0; i < 140000 && m_cons != 16'hFFFF; i++) tick(1);
    done = 1'b0;
    tick(2);
    chk("R4", "full chain idle", 64'(state), 64'd2);
    do_count(16'd1);
    done = 1'b1;
    tick(6);
    done = 1'b0;
    tick(1);
    chk("R4", "wrapped count", 64'(consumed), 64'd1);
    chk("R4", "idle after wrap", 64'(state), 64'd2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule